// File: doc/BRIEF.md
# Configuration-Load Error Supervisor

This block supervises the power-up configuration load, in which a loader reads configuration blocks out of a serial EEPROM through a master SMBus. The loader and the bus master report events to the block as single-cycle strobes:

- a checksum comparison result
- each step of the EEPROM address, together with the address it steps from
- the type field of each configuration block
- an unexpected NACK
- a lost or won arbitration attempt
- a START or STOP seen where none may appear
- a clean end of the load

The block sorts these events into four sticky error classes. On the first fault it raises a reset-halt flag, pulses an abort request for one cycle and marks the load as done. A clean end marks the load done without halting.

The first fault, or a clean end, closes the load. From then on every event strobe is ignored until reset. The error bits remain readable, and they can be cleared one at a time with a write-one-to-clear strobe. The reset-halt and done flags hold until reset.

Top module: `cfgFaultSup`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, errStatus, rstHalt, doneFlag and abortReq are all 0.
- R2: A checksum strobe (chkValid=1) with chkMatch=0 sets errStatus bit 0 one clock later. With chkMatch=1 it has no effect.
- R3: An address step (addrInc=1) taken from addrCur equal to all ones (0xFFFF at the default width) is a wrap and sets errStatus bit 0. A step from any other address has no effect.
- R4: A block-type strobe (typeValid=1) with typeVal equal to 2 sets errStatus bit 0. Every other type value is accepted and has no effect.
- R5: An unexpected NACK strobe (nackSeen=1) sets errStatus bit 1.
- R6: The 16th lost arbitration (arbLost=1) in a row sets errStatus bit 2. A won arbitration (arbWon=1) restarts the run from zero, and it takes priority when both strobes arrive in the same cycle.
- R7: A misplaced START/STOP strobe (badCond=1) sets errStatus bit 3.
- R8: One clock after any accepted fault, rstHalt and doneFlag are set. abortReq is 1 for exactly that one cycle.
- R9: Only the first fault cycle is acted on. Every fault present in that cycle sets its bit. Once doneFlag is 1, all event strobes, loadDone included, are ignored until reset.
- R10: A loadDone strobe with no fault present sets doneFlag only, leaving rstHalt, abortReq and errStatus at 0. If a fault arrives in the same cycle, the fault wins.
- R11: A clrWr strobe clears each errStatus bit whose clrMask bit is 1, one clock later. It does not change rstHalt or doneFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chkValid | input | 1 | Checksum comparison strobe |
| chkMatch | input | 1 | Checksum comparison result, 1 = equal |
| addrInc | input | 1 | EEPROM address step strobe |
| addrCur | input | ADDR_W | Address being stepped from |
| typeValid | input | 1 | Block-type strobe |
| typeVal | input | TYPE_W | Block-type field value |
| nackSeen | input | 1 | Unexpected NACK strobe |
| arbLost | input | 1 | Arbitration attempt lost |
| arbWon | input | 1 | Arbitration attempt won |
| badCond | input | 1 | Misplaced START/STOP strobe |
| loadDone | input | 1 | Clean end of load strobe |
| clrWr | input | 1 | Write-one-to-clear strobe for errStatus |
| clrMask | input | 4 | Bits of errStatus to clear |
| errStatus | output | 4 | Sticky errors: 0 checksum class, 1 NACK, 2 arbitration, 3 misplaced condition |
| rstHalt | output | 1 | Reset sequencing halt |
| doneFlag | output | 1 | Load finished, by fault or cleanly |
| abortReq | output | 1 | One-cycle abort request |

## Verification
Every result in this block is due exactly one clock after the edge that samples its strobe. The only exception is the arbitration fault, which is due one clock after the 16th consecutive loss, so a run of 15 losses must leave the outputs untouched. The bench drives each stimulus on the falling edge and advances its model by one step per rising edge. It compares all four outputs on the next falling edge, before it changes any input, so each comparison sees exactly the effect of the previous cycle's strobes. Directed runs place strobes on the wrap address, on the bad type value, on the 15th and 16th losses and in the same cycle as loadDone. Random runs then mix all strobes, reset between runs.

// File: rtl/cfgSupPkg.sv
package cfgSupPkg;

  localparam int NUM_ERR   = 4;
  localparam int ERR_CKSUM = 0;
  localparam int ERR_NACK  = 1;
  localparam int ERR_ARB   = 2;
  localparam int ERR_OTHER = 3;

  typedef enum logic {
    ST_LOADING = 1'b0,
    ST_CLOSED  = 1'b1
  } supState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // first fault: record classes, halt, abort, done
    logic finish;   // clean end: done only
  } supCmd_t;

endpackage

// File: rtl/cfgSupControl.sv
module cfgSupControl
  import cfgSupPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    anyFault,
  input  logic    loadDone,
  output supCmd_t cmd
);

  supState_e state;

  always_comb begin
    cmd.capture = (state == ST_LOADING) && anyFault;
    cmd.finish  = (state == ST_LOADING) && !anyFault && loadDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_LOADING;
    end else if (cmd.capture || cmd.finish) begin
      state <= ST_CLOSED;
    end
  end

endmodule

// File: rtl/cfgSupDatapath.sv
module cfgSupDatapath
  import cfgSupPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int TYPE_W    = 4,
  parameter int BAD_TYPE  = 2,
  parameter int ARB_LIMIT = 16   // must be 2 or more
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chkValid,
  input  logic               chkMatch,
  input  logic               addrInc,
  input  logic [ADDR_W-1:0]  addrCur,
  input  logic               typeValid,
  input  logic [TYPE_W-1:0]  typeVal,
  input  logic               nackSeen,
  input  logic               arbLost,
  input  logic               arbWon,
  input  logic               badCond,
  input  logic               clrWr,
  input  logic [NUM_ERR-1:0] clrMask,
  input  supCmd_t            cmd,
  output logic               anyFault,
  output logic [NUM_ERR-1:0] errStatus,
  output logic               rstHalt,
  output logic               doneFlag,
  output logic               abortReq
);

  localparam int CNT_W = $clog2(ARB_LIMIT);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(ARB_LIMIT - 1);
  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;
  localparam logic [TYPE_W-1:0] TYPE_BAD = TYPE_W'(BAD_TYPE);

  logic [CNT_W-1:0]   lossRun;
  logic [NUM_ERR-1:0] faultVec;

  // classify events into error classes
  always_comb begin
    faultVec            = '0;
    faultVec[ERR_CKSUM] = (chkValid && !chkMatch)
                        || (addrInc && (addrCur == ADDR_TOP))
                        || (typeValid && (typeVal == TYPE_BAD));
    faultVec[ERR_NACK]  = nackSeen;
    faultVec[ERR_ARB]   = arbLost && !arbWon && (lossRun == CNT_LAST);
    faultVec[ERR_OTHER] = badCond;
  end

  assign anyFault = |faultVec;

  // consecutive arbitration loss run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lossRun <= '0;
    end else if (arbWon) begin
      lossRun <= '0;
    end else if (arbLost && (lossRun != CNT_LAST)) begin
      lossRun <= lossRun + 1'b1;
    end
  end

  // sticky error bits, set beats clear
  for (genvar i = 0; i < NUM_ERR; i++) begin : g_errBit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        errStatus[i] <= 1'b0;
      end else if (cmd.capture && faultVec[i]) begin
        errStatus[i] <= 1'b1;
      end else if (clrWr && clrMask[i]) begin
        errStatus[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstHalt  <= 1'b0;
      doneFlag <= 1'b0;
      abortReq <= 1'b0;
    end else begin
      abortReq <= cmd.capture;
      if (cmd.capture) begin
        rstHalt <= 1'b1;
      end
      if (cmd.capture || cmd.finish) begin
        doneFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfgFaultSup.sv
module cfgFaultSup
  import cfgSupPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int TYPE_W    = 4,
  parameter int BAD_TYPE  = 2,
  parameter int ARB_LIMIT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chkValid,
  input  logic               chkMatch,
  input  logic               addrInc,
  input  logic [ADDR_W-1:0]  addrCur,
  input  logic               typeValid,
  input  logic [TYPE_W-1:0]  typeVal,
  input  logic               nackSeen,
  input  logic               arbLost,
  input  logic               arbWon,
  input  logic               badCond,
  input  logic               loadDone,
  input  logic               clrWr,
  input  logic [3:0]         clrMask,
  output logic [3:0]         errStatus,
  output logic               rstHalt,
  output logic               doneFlag,
  output logic               abortReq
);

  supCmd_t cmd;
  logic    anyFault;

  cfgSupControl i_control (
    .clk      (clk),
    .rstN     (rstN),
    .anyFault (anyFault),
    .loadDone (loadDone),
    .cmd      (cmd)
  );

  cfgSupDatapath #(
    .ADDR_W    (ADDR_W),
    .TYPE_W    (TYPE_W),
    .BAD_TYPE  (BAD_TYPE),
    .ARB_LIMIT (ARB_LIMIT)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .chkValid  (chkValid),
    .chkMatch  (chkMatch),
    .addrInc   (addrInc),
    .addrCur   (addrCur),
    .typeValid (typeValid),
    .typeVal   (typeVal),
    .nackSeen  (nackSeen),
    .arbLost   (arbLost),
    .arbWon    (arbWon),
    .badCond   (badCond),
    .clrWr     (clrWr),
    .clrMask   (clrMask),
    .cmd       (cmd),
    .anyFault  (anyFault),
    .errStatus (errStatus),
    .rstHalt   (rstHalt),
    .doneFlag  (doneFlag),
    .abortReq  (abortReq)
  );

endmodule

// File: rtl/cfgSupChecker.sv
module cfgSupChecker #(
  parameter int ADDR_W   = 16,
  parameter int TYPE_W   = 4,
  parameter int BAD_TYPE = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              chkValid,
  input logic              chkMatch,
  input logic              addrInc,
  input logic [ADDR_W-1:0] addrCur,
  input logic              typeValid,
  input logic [TYPE_W-1:0] typeVal,
  input logic              nackSeen,
  input logic              badCond,
  input logic [3:0]        errStatus,
  input logic              rstHalt,
  input logic              doneFlag,
  input logic              abortReq
);

  // R2
  cksum_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && !chkMatch && !doneFlag) |=> errStatus[0]);

  // R3
  wrap_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrInc && (addrCur == '1) && !doneFlag) |=> errStatus[0]);

  // R4
  bad_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    (typeValid && (typeVal == TYPE_W'(BAD_TYPE)) && !doneFlag) |=> errStatus[0]);

  // R5
  nack_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nackSeen && !doneFlag) |=> errStatus[1]);

  // R7
  bad_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (badCond && !doneFlag) |=> errStatus[3]);

  // R8
  abort_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !abortReq);

  // R8
  abort_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> (rstHalt && doneFlag));

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstHalt |=> (rstHalt && doneFlag));

  // R9
  no_new_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> ((errStatus & ~$past(errStatus)) == 4'b0000));

  // R10
  err_needs_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errStatus != 4'b0000) |-> rstHalt);

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> doneFlag);

endmodule

bind cfgFaultSup cfgSupChecker #(
  .ADDR_W   (ADDR_W),
  .TYPE_W   (TYPE_W),
  .BAD_TYPE (BAD_TYPE)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .chkValid  (chkValid),
  .chkMatch  (chkMatch),
  .addrInc   (addrInc),
  .addrCur   (addrCur),
  .typeValid (typeValid),
  .typeVal   (typeVal),
  .nackSeen  (nackSeen),
  .badCond   (badCond),
  .errStatus (errStatus),
  .rstHalt   (rstHalt),
  .doneFlag  (doneFlag),
  .abortReq  (abortReq)
);

// File: tb/test_cfgFaultSup.sv
module test_cfgFaultSup;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chkValid, chkMatch, addrInc, typeValid;
  logic [15:0] addrCur;
  logic [3:0]  typeVal;
  logic        nackSeen, arbLost, arbWon, badCond, loadDone, clrWr;
  logic [3:0]  clrMask;
  logic [3:0]  errStatus;
  logic        rstHalt, doneFlag, abortReq;

  int vectors = 0;
  int misses  = 0;

  // bench model state
  logic [3:0] mErr;
  logic       mHalt, mDone, mAbort;
  int         mRun;

  always #10 clk = ~clk;  // 50 MHz

  cfgFaultSup i_cfgFaultSup (
    .clk(clk), .rstN(rstN), .chkValid(chkValid), .chkMatch(chkMatch),
    .addrInc(addrInc), .addrCur(addrCur), .typeValid(typeValid),
    .typeVal(typeVal), .nackSeen(nackSeen), .arbLost(arbLost),
    .arbWon(arbWon), .badCond(badCond), .loadDone(loadDone),
    .clrWr(clrWr), .clrMask(clrMask), .errStatus(errStatus),
    .rstHalt(rstHalt), .doneFlag(doneFlag), .abortReq(abortReq)
  );

  function automatic logic [3:0] faultsNow(int run);
    logic [3:0] f;
    f[0] = (chkValid && !chkMatch) || (addrInc && addrCur == 16'hFFFF)
         || (typeValid && typeVal == 4'd2);
    f[1] = nackSeen;
    f[2] = arbLost && !arbWon && (run == 15);
    f[3] = badCond;
    return f;
  endfunction

  task automatic modelStep();
    logic [3:0] f;
    f = faultsNow(mRun);
    if (clrWr) mErr = mErr & ~clrMask;
    mAbort = 1'b0;
    if (!mDone) begin
      if (f != 4'b0000) begin
        mErr   = mErr | f;
        mHalt  = 1'b1;
        mDone  = 1'b1;
        mAbort = 1'b1;
      end else if (loadDone) begin
        mDone = 1'b1;
      end
    end
    if (arbWon) mRun = 0;
    else if (arbLost && mRun < 15) mRun = mRun + 1;
  endtask

  task automatic check(string tag, string what, logic [3:0] act, logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(string tag);
    check(tag, "errStatus", errStatus, mErr);
    check(tag, "rstHalt", {3'b0, rstHalt}, {3'b0, mHalt});
    check(tag, "doneFlag", {3'b0, doneFlag}, {3'b0, mDone});
    check(tag, "abortReq", {3'b0, abortReq}, {3'b0, mAbort});
  endtask

  task automatic clearIns();
    chkValid = 0; chkMatch = 0; addrInc = 0; addrCur = '0; typeValid = 0;
    typeVal = '0; nackSeen = 0; arbLost = 0; arbWon = 0; badCond = 0;
    loadDone = 0; clrWr = 0; clrMask = '0;
  endtask

  // inputs were set at a falling edge; result is due at the next one
  task automatic tick(string tag);
    modelStep();
    @(negedge clk);
    compareAll(tag);
    clearIns();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    clearIns();
    mErr = '0; mHalt = 0; mDone = 0; mAbort = 0; mRun = 0;
    repeat (2) @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    tick("R1");
  endtask

  initial begin
    #(20 * 150000);
    misses++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    clearIns();
    @(negedge clk);
    doReset();

    // R2: match is harmless, mismatch faults
    chkValid = 1; chkMatch = 1; tick("R2");
    chkValid = 1; chkMatch = 0; tick("R2");
    tick("R8");

    // R3: wrap only from all ones
    doReset();
    addrInc = 1; addrCur = 16'hFFFE; tick("R3");
    addrInc = 1; addrCur = 16'h0000; tick("R3");
    addrInc = 1; addrCur = 16'hFFFF; tick("R3");

    // R4: only type 2 is invalid
    doReset();
    for (int t = 0; t < 16; t++) begin
      if (t != 2) begin
        typeValid = 1; typeVal = 4'(t); tick("R4");
      end
    end
    typeValid = 1; typeVal = 4'd2; tick("R4");

    // R5
    doReset();
    nackSeen = 1; tick("R5");
    tick("R8");

    // R6: 15 losses, win, 15 losses, then the 16th
    doReset();
    repeat (15) begin arbLost = 1; tick("R6"); end
    arbWon = 1; arbLost = 1; tick("R6");
    repeat (15) begin arbLost = 1; tick("R6"); end
    arbLost = 1; tick("R6");
    tick("R8");

    // R7
    doReset();
    badCond = 1; tick("R7");

    // R10 then R9: clean end closes the load
    doReset();
    loadDone = 1; tick("R10");
    nackSeen = 1; badCond = 1; tick("R9");
    chkValid = 1; chkMatch = 0; tick("R9");

    // R9: simultaneous faults, later events ignored; R11 clears
    doReset();
    nackSeen = 1; badCond = 1; tick("R9");
    chkValid = 1; chkMatch = 0; loadDone = 1; tick("R9");
    clrWr = 1; clrMask = 4'b0010; tick("R11");
    clrWr = 1; clrMask = 4'b1111; tick("R11");

    // R10: fault wins over simultaneous clean end
    doReset();
    loadDone = 1; nackSeen = 1; tick("R10");

    // random sessions
    for (int s = 0; s < 40; s++) begin
      doReset();
      for (int c = 0; c < 250; c++) begin
        chkValid  = ($urandom_range(99) < 2);
        chkMatch  = $urandom_range(1);
        addrInc   = ($urandom_range(99) < 30);
        addrCur   = ($urandom_range(99) < 5) ? 16'hFFFF : 16'($urandom);
        typeValid = ($urandom_range(99) < 5);
        typeVal   = 4'($urandom_range(15));
        nackSeen  = ($urandom_range(199) < 1);
        arbLost   = ($urandom_range(99) < 60);
        arbWon    = ($urandom_range(99) < 3);
        badCond   = ($urandom_range(199) < 1);
        loadDone  = ($urandom_range(99) < 1);
        clrWr     = ($urandom_range(99) < 5);
        clrMask   = 4'($urandom_range(15));
        tick("R9");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule